// File: doc/BRIEF.md
# Integer Instruction Decode and Execute Unit

This unit takes one 32-bit fixed-length instruction per clock cycle, works out its format, reads up to two source registers from a 32-entry register file, and computes a result for a small integer subset. The supported operations are register add, subtract and signed set-less-than, plus immediate add, set-less-than, AND, OR and load-upper.

The unit presents the destination index, the write enable and the result value combinationally from the current instruction. The register file stores the result on the next rising clock edge. Register 0 is a constant zero.

Memory opcodes are recognised but produce no register write, so a surrounding pipeline can route them elsewhere. Any opcode or function code outside the subset behaves the same way. The unit is meant to sit at the execute stage of a simple in-order core. A caller can observe any register by issuing an OR-immediate of that register with zero into itself.

Top module: `int_exec_unit`

## Requirements
- R1: The destination index is the field at bits [15:11] for register-format instructions (opcode 0) and the field at bits [20:16] for immediate-format instructions. The first source is always bits [25:21], and the second register source is bits [20:16].
- R2: Register-format add (function code 32 in bits [5:0]) and subtract (function code 34) produce the 32-bit two's complement sum or difference, wrapping modulo 2^32.
- R3: Register-format set-less-than (function code 42) yields 1 when the first source is smaller than the second under a signed comparison, and 0 otherwise.
- R4: Add-immediate (opcode 8) and set-less-than-immediate (opcode 10) sign-extend the 16-bit immediate in bits [15:0]. The latter uses a signed comparison.
- R5: AND-immediate (opcode 12) and OR-immediate (opcode 13) zero-extend the 16-bit immediate.
- R6: Load-upper (opcode 15) produces the immediate in bits [31:16] and zeros in bits [15:0], independent of the source register.
- R7: The result, destination index and write enable follow the instruction combinationally. On the next rising clock edge the result is stored, and later reads of that register return it.
- R8: Register 0 reads as zero. An instruction whose destination is register 0 deasserts the write enable and leaves every register unchanged.
- R9: Load-word (opcode 35), store-word (opcode 43), every other unsupported opcode, and unsupported function codes under opcode 0 deassert the write enable and change no register.
- R10: While the active-low asynchronous reset is asserted, every register clears to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction executed this cycle |
| wr_en_o | output | 1 | Result is written to the register file at the next edge |
| wr_addr_o | output | 5 | Destination register index |
| wr_data_o | output | 32 | Computed result |

## Verification
The assertions take for granted that `instr_i` carries a known value at every rising edge, and that reset is released only with a defined instruction present. Their format and opcode checks are read straight from the instruction fields, with no history. The bench meets these conditions by driving `instr_i` only on falling edges, from reset onward, and by parking the input on a load-word encoding whenever no scenario is active. That encoding never writes a register, so idle cycles cannot disturb the state that later checks read back.

// File: rtl/iex_pkg.sv
package iex_pkg;
  localparam int INSTR_W   = 32;
  localparam int OP_W      = 6;
  localparam int RIDX_W    = 5;
  localparam int FUNCT_W   = 6;
  localparam int IMM_W     = 16;
  localparam int NUM_REGS  = 1 << RIDX_W;

  // field positions (decoded by neighbours, so fixed)
  localparam int OP_LSB    = INSTR_W - OP_W;
  localparam int RS_LSB    = OP_LSB - RIDX_W;
  localparam int RT_LSB    = RS_LSB - RIDX_W;
  localparam int RD_LSB    = RT_LSB - RIDX_W;

  localparam logic [OP_W-1:0] OP_REG  = 6'd0;
  localparam logic [OP_W-1:0] OP_ADDI = 6'd8;
  localparam logic [OP_W-1:0] OP_SLTI = 6'd10;
  localparam logic [OP_W-1:0] OP_ANDI = 6'd12;
  localparam logic [OP_W-1:0] OP_ORI  = 6'd13;
  localparam logic [OP_W-1:0] OP_LUI  = 6'd15;
  localparam logic [OP_W-1:0] OP_LDW  = 6'd35;
  localparam logic [OP_W-1:0] OP_STW  = 6'd43;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'd32;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'd34;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLT,
    ALU_AND,
    ALU_OR,
    ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG,
    OPB_SEXT,
    OPB_ZEXT,
    OPB_UPPER
  } opb_sel_e;

  typedef struct packed {
    logic     writes;
    logic     dst_is_rd;
    alu_op_e  alu_op;
    opb_sel_e opb_sel;
  } ctrl_t;
endpackage

// File: rtl/iex_decoder.sv
module iex_decoder
  import iex_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output ctrl_t              ctrl_o,
  output logic [RIDX_W-1:0]  rs_o,
  output logic [RIDX_W-1:0]  rt_o,
  output logic [RIDX_W-1:0]  dst_o,
  output logic [IMM_W-1:0]   imm_o
);
  logic [OP_W-1:0]    op;
  logic [FUNCT_W-1:0] funct;
  logic [RIDX_W-1:0]  rd;

  assign op    = instr_i[OP_LSB +: OP_W];
  assign rs_o  = instr_i[RS_LSB +: RIDX_W];
  assign rt_o  = instr_i[RT_LSB +: RIDX_W];
  assign rd    = instr_i[RD_LSB +: RIDX_W];
  assign funct = instr_i[FUNCT_W-1:0];
  assign imm_o = instr_i[IMM_W-1:0];

  always_comb begin
    ctrl_o = '{writes: 1'b0, dst_is_rd: 1'b0, alu_op: ALU_ADD, opb_sel: OPB_REG};
    unique case (op)
      OP_REG: begin
        ctrl_o.dst_is_rd = 1'b1;
        unique case (funct)
          FN_ADD:  begin ctrl_o.writes = 1'b1; ctrl_o.alu_op = ALU_ADD; end
          FN_SUB:  begin ctrl_o.writes = 1'b1; ctrl_o.alu_op = ALU_SUB; end
          FN_SLT:  begin ctrl_o.writes = 1'b1; ctrl_o.alu_op = ALU_SLT; end
          default: ctrl_o.writes = 1'b0;
        endcase
      end
      OP_ADDI: begin ctrl_o.writes = 1'b1; ctrl_o.alu_op = ALU_ADD;   ctrl_o.opb_sel = OPB_SEXT;  end
      OP_SLTI: begin ctrl_o.writes = 1'b1; ctrl_o.alu_op = ALU_SLT;   ctrl_o.opb_sel = OPB_SEXT;  end
      OP_ANDI: begin ctrl_o.writes = 1'b1; ctrl_o.alu_op = ALU_AND;   ctrl_o.opb_sel = OPB_ZEXT;  end
      OP_ORI:  begin ctrl_o.writes = 1'b1; ctrl_o.alu_op = ALU_OR;    ctrl_o.opb_sel = OPB_ZEXT;  end
      OP_LUI:  begin ctrl_o.writes = 1'b1; ctrl_o.alu_op = ALU_PASSB; ctrl_o.opb_sel = OPB_UPPER; end
      // memory ops decoded explicitly; handled outside this unit
      OP_LDW, OP_STW: ctrl_o.writes = 1'b0;
      default:        ctrl_o.writes = 1'b0;
    endcase
  end

  assign dst_o = ctrl_o.dst_is_rd ? rd : rt_o;
endmodule

// File: rtl/iex_regfile.sv
module iex_regfile #(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NREG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             waddr_i,
  input  logic [XLEN-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0]    raddr_i,
  output logic [NRD-1:0][XLEN-1:0]  rdata_o
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : regs_q[raddr_i[p]];
  end
endmodule

// File: rtl/iex_alu.sv
module iex_alu
  import iex_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e          alu_op_i,
  input  opb_sel_e         opb_sel_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_reg_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  res_o
);
  logic [XLEN-1:0] b;

  always_comb begin
    unique case (opb_sel_i)
      OPB_SEXT:  b = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
      OPB_ZEXT:  b = XLEN'(imm_i);
      OPB_UPPER: b = XLEN'(imm_i) << IMM_W;
      default:   b = b_reg_i;
    endcase
  end

  always_comb begin
    unique case (alu_op_i)
      ALU_ADD:   res_o = a_i + b;
      ALU_SUB:   res_o = a_i - b;
      ALU_SLT:   res_o = XLEN'($signed(a_i) < $signed(b));
      ALU_AND:   res_o = a_i & b;
      ALU_OR:    res_o = a_i | b;
      ALU_PASSB: res_o = b;
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iex_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               wr_en_o,
  output logic [RIDX_W-1:0]  wr_addr_o,
  output logic [XLEN-1:0]    wr_data_o
);
  ctrl_t                       ctrl;
  logic [RIDX_W-1:0]           rs, rt, dst;
  logic [IMM_W-1:0]            imm;
  logic [1:0][RIDX_W-1:0]      raddr;
  logic [1:0][XLEN-1:0]        rdata;

  iex_decoder u_dec (
    .instr_i (instr_i),
    .ctrl_o  (ctrl),
    .rs_o    (rs),
    .rt_o    (rt),
    .dst_o   (dst),
    .imm_o   (imm)
  );

  assign raddr = {rt, rs};

  iex_regfile #(.XLEN(XLEN), .NREG(NUM_REGS), .NRD(2)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_o),
    .waddr_i (wr_addr_o),
    .wdata_i (wr_data_o),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  iex_alu #(.XLEN(XLEN)) u_alu (
    .alu_op_i  (ctrl.alu_op),
    .opb_sel_i (ctrl.opb_sel),
    .a_i       (rdata[0]),
    .b_reg_i   (rdata[1]),
    .imm_i     (imm),
    .res_o     (wr_data_o)
  );

  assign wr_addr_o = dst;
  assign wr_en_o   = ctrl.writes && (dst != '0);
endmodule

// File: rtl/int_exec_unit_checker.sv
module iex_checker
  import iex_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [INSTR_W-1:0] instr_i,
  input logic               wr_en_o,
  input logic [RIDX_W-1:0]  wr_addr_o,
  input logic [XLEN-1:0]    wr_data_o
);
  logic [OP_W-1:0] op;
  assign op = instr_i[OP_LSB +: OP_W];

  a_r1_reg_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && op == OP_REG) |-> wr_addr_o == instr_i[RD_LSB +: RIDX_W]);

  a_r1_imm_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && op != OP_REG) |-> wr_addr_o == instr_i[RT_LSB +: RIDX_W]);

  a_r3_slt_bool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && (op == OP_SLTI || (op == OP_REG && instr_i[FUNCT_W-1:0] == FN_SLT)))
      |-> wr_data_o[XLEN-1:1] == '0);

  a_r5_andi_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && op == OP_ANDI) |-> wr_data_o[XLEN-1:IMM_W] == '0);

  a_r6_lui_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && op == OP_LUI) |-> wr_data_o[IMM_W-1:0] == '0);

  a_r8_no_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_addr_o != '0);

  a_r9_mem_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_LDW || op == OP_STW) |-> !wr_en_o);
endmodule

bind int_exec_unit iex_checker #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .instr_i   (instr_i),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o)
);

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i;
  logic        wr_en_o;
  logic [4:0]  wr_addr_o;
  logic [31:0] wr_data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int_exec_unit uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .instr_i   (instr_i),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  localparam logic [31:0] IDLE = {6'd35, 5'd0, 5'd0, 16'd0};

  function automatic logic [31:0] enc_r(input int rs, rt, rd, fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(input int op, rs, rt, input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  // drive on falling edge, sample a quarter period later; commit at next rising edge
  task automatic issue(input logic [31:0] ins);
    @(negedge clk_i);
    instr_i = ins;
    #(CLK_PERIOD/4);
  endtask

  task automatic exec_chk(input string req, input logic [31:0] ins,
                          input logic en, input logic [4:0] addr, input logic [31:0] data);
    issue(ins);
    chk(req, "wr_en", 32'(wr_en_o), 32'(en));
    if (en) begin
      chk(req, "wr_addr", 32'(wr_addr_o), 32'(addr));
      chk(req, "wr_data", wr_data_o, data);
    end
  endtask

  // read a register by OR-ing it with zero into itself
  task automatic peek_chk(input string req, input int r, input logic [31:0] exp);
    issue(enc_i(13, r, r, 16'h0000));
    chk(req, $sformatf("reg%0d", r), wr_data_o, exp);
  endtask

  task automatic t_reset;
    for (int r = 0; r < 32; r += 7) peek_chk("R10", r, 32'h0);
    exec_chk("R9", IDLE, 1'b0, 5'd0, 32'h0);
  endtask

  task automatic t_lui;
    exec_chk("R6", enc_i(15, 3, 1, 16'h8000), 1'b1, 5'd1, 32'h8000_0000);
    exec_chk("R5", enc_i(13, 1, 1, 16'h1234), 1'b1, 5'd1, 32'h8000_1234);
    peek_chk("R7", 1, 32'h8000_1234);
  endtask

  task automatic t_imm;
    exec_chk("R4", enc_i(8, 0, 2, 16'hFFFF), 1'b1, 5'd2, 32'hFFFF_FFFF);
    exec_chk("R5", enc_i(12, 2, 3, 16'hF0F0), 1'b1, 5'd3, 32'h0000_F0F0);
    exec_chk("R5", enc_i(13, 0, 4, 16'h8001), 1'b1, 5'd4, 32'h0000_8001);
    exec_chk("R4", enc_i(10, 2, 5, 16'h0000), 1'b1, 5'd5, 32'h1);
    exec_chk("R4", enc_i(10, 4, 6, 16'hFFFF), 1'b1, 5'd6, 32'h0);
    exec_chk("R4", enc_i(8, 4, 6, 16'h8000), 1'b1, 5'd6, 32'h0000_0001);
    exec_chk("R6", enc_i(15, 1, 7, 16'h00AB), 1'b1, 5'd7, 32'h00AB_0000);
  endtask

  task automatic t_rtype;
    exec_chk("R2", enc_r(1, 4, 7, 32), 1'b1, 5'd7, 32'h8000_9235);
    exec_chk("R1", enc_r(4, 1, 20, 32), 1'b1, 5'd20, 32'h8000_9235);
    exec_chk("R2", enc_r(0, 2, 8, 34), 1'b1, 5'd8, 32'h0000_0001);
    exec_chk("R2", enc_r(1, 1, 9, 32), 1'b1, 5'd9, 32'h0000_2468);
    exec_chk("R2", enc_r(4, 1, 9, 34), 1'b1, 5'd9, 32'h8000_6DCD);
    exec_chk("R3", enc_r(1, 4, 10, 42), 1'b1, 5'd10, 32'h1);
    exec_chk("R3", enc_r(4, 1, 11, 42), 1'b1, 5'd11, 32'h0);
    exec_chk("R3", enc_r(4, 4, 12, 42), 1'b1, 5'd12, 32'h0);
    peek_chk("R7", 9, 32'h8000_6DCD);
  endtask

  task automatic t_zero;
    exec_chk("R8", enc_i(8, 4, 0, 16'h0005), 1'b0, 5'd0, 32'h0);
    exec_chk("R8", enc_r(1, 4, 0, 32), 1'b0, 5'd0, 32'h0);
    peek_chk("R8", 0, 32'h0);
    exec_chk("R8", enc_r(0, 0, 13, 32), 1'b1, 5'd13, 32'h0);
  endtask

  task automatic t_nowrite;
    exec_chk("R9", enc_i(35, 1, 14, 16'h0004), 1'b0, 5'd0, 32'h0);
    exec_chk("R9", enc_i(43, 1, 14, 16'h0004), 1'b0, 5'd0, 32'h0);
    exec_chk("R9", enc_r(1, 4, 14, 37), 1'b0, 5'd0, 32'h0);
    exec_chk("R9", enc_i(4, 1, 14, 16'h0001), 1'b0, 5'd0, 32'h0);
    exec_chk("R9", enc_i(9, 1, 14, 16'h0001), 1'b0, 5'd0, 32'h0);
    peek_chk("R9", 14, 32'h0);
  endtask

  task automatic t_rereset;
    @(negedge clk_i);
    instr_i = IDLE;
    rst_ni  = 1'b0;
    #(CLK_PERIOD/4);
    rst_ni  = 1'b1;
    peek_chk("R10", 1, 32'h0);
    peek_chk("R10", 9, 32'h0);
  endtask

  initial begin
    instr_i = IDLE;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_lui();
    t_imm();
    t_rtype();
    t_zero();
    t_nowrite();
    t_rereset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule